// File: doc/BRIEF.md
# Snooping Write-Through Invalidate Cache

This block is a small direct-mapped private cache for one processor on a shared bus with several masters. Each line holds one data word, a tag and a valid bit. Reads that hit are answered from the line store. Reads that miss fetch the word over the bus, install it and return it. Every processor write goes out to memory over the bus. A write that hits also updates the cached copy. A write that misses leaves the line store alone.

Coherence comes only from invalidation. The cache watches a snoop input that reports each write placed on the bus. If a write from another master (a processor or an I/O processor) hits a valid line, that line is cleared, and the next processor reference to it misses and refetches from memory. The cache ignores snooped writes that carry its own source number.

The processor request channel, the processor response channel and the bus request channel are valid/ready streams. A producer holds valid, and every payload field, stable until the cycle in which ready is also high. The cache takes one processor request at a time: request ready is high only while no access is in flight. It holds its response until the processor accepts it. The bus read response is a single-cycle pulse with no back-pressure. All addresses are word addresses.

Top module: `snoop_wt_cache`

## Requirements
- R1: Reset clears every valid bit. In the first cycle after reset, request ready is 1 and both response valid and bus request valid are 0. The first read of any address after reset misses.
- R2: A read that hits produces no bus transaction. Its response is valid in the first cycle after the request is accepted and carries the cached word.
- R3: A read that misses issues exactly one bus read (bus write flag 0) of the requested word address. The cache raises no other bus request until the read response arrives. It then installs the word as a valid line and returns it to the processor.
- R4: Every processor write causes exactly one bus write (bus write flag 1), in the cycle after acceptance, with the request's address and data. A write hit updates the cached word. A write miss installs nothing, so a later read of that address misses.
- R5: A snooped write from another source whose word address matches a valid line clears that line. The next read of that address misses and returns the memory value.
- R6: A snooped write whose source equals SELF_ID changes nothing: a valid line stays valid and keeps hitting.
- R7: When a qualified snoop and a processor request for the same word are accepted in the same cycle, the invalidation is applied first. A read misses and issues a bus read in the next cycle. A write updates memory but leaves the line invalid.
- R8: If a qualified snoop matches the word of a read miss between its acceptance and its fill, the fetched word is still returned to the processor but the line is left invalid, so the next read misses.
- R9: A qualified snoop that maps to the same line index but has a different tag leaves that line valid.
- R10: The response holds valid and data stable while response ready is low. A bus request holds valid, write flag, address and data stable while bus ready is low. Request ready is low whenever a bus request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | Processor accepts the response |
| cpu_rsp_rdata | output | DATA_W | Read data |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus accepts the request |
| bus_req_write | output | 1 | 1 = bus write, 0 = bus read |
| bus_req_addr | output | ADDR_W | Bus word address |
| bus_req_wdata | output | DATA_W | Bus write data |
| bus_rsp_valid | input | 1 | One-cycle read data pulse |
| bus_rsp_rdata | input | DATA_W | Read data from memory |
| snp_valid | input | 1 | A write is on the bus |
| snp_src | input | SRC_W | Source number of that write |
| snp_addr | input | ADDR_W | Word address of that write |

## Verification
The hardest case to reach from the ports is a snooped write to the very word a read miss is fetching, arriving while the fill is still in flight. The stimulus pins the bus to accept at once and stretches the read latency to eight cycles. It then forks a snoop that lands three cycles after the processor request. The bench checks that the stale word is returned and that the following read goes back to the bus. The same-cycle race is driven by putting a request and a snoop on the same edge, for both reads and writes. Random traffic over a few tags on four line indices keeps conflicts, write hits, self-sourced snoops and response back-pressure frequent.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_RESP    = 3'd4
  } wtc_state_e;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int LINES  = 16,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 26,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_valid,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [DATA_W-1:0] lk_data,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [DATA_W-1:0] upd_data,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_ok,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx,
  input  logic [TAG_W-1:0]  inv_tag
);
  logic              vld_v  [LINES];
  logic [TAG_W-1:0]  tag_v  [LINES];
  logic [DATA_W-1:0] data_v [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              vld_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] data_r;
    logic              fill_here;
    logic [TAG_W-1:0]  eff_tag;
    logic              kill;

    // the snoop is compared against the tag the line holds after this cycle
    assign fill_here = fill_en && (fill_idx == IDX_W'(g));
    assign eff_tag   = fill_here ? fill_tag : tag_r;
    assign kill      = inv_en && (inv_idx == IDX_W'(g)) && (eff_tag == inv_tag);

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_r <= 1'b0;
      end else if (kill) begin
        vld_r <= 1'b0;
      end else if (fill_here) begin
        vld_r <= fill_ok;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_here) begin
        tag_r  <= fill_tag;
        data_r <= fill_data;
      end else if (upd_en && (upd_idx == IDX_W'(g))) begin
        data_r <= upd_data;
      end
    end

    assign vld_v[g]  = vld_r;
    assign tag_v[g]  = tag_r;
    assign data_v[g] = data_r;
  end

  assign lk_valid = vld_v[lk_idx];
  assign lk_tag   = tag_v[lk_idx];
  assign lk_data  = data_v[lk_idx];
endmodule

// File: rtl/wtc_snoop_port.sv
module wtc_snoop_port #(
  parameter int ADDR_W  = 30,
  parameter int IDX_W   = 4,
  parameter int SRC_W   = 3,
  parameter int SELF_ID = 0,
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              snp_valid,
  input  logic [SRC_W-1:0]  snp_src,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              inv_en,
  output logic [IDX_W-1:0]  inv_idx,
  output logic [TAG_W-1:0]  inv_tag,
  output logic [ADDR_W-1:0] inv_word
);
  // writes carrying our own source number are the cache's own write-through
  assign inv_en   = snp_valid && (snp_src != SRC_W'(SELF_ID));
  assign inv_idx  = snp_addr[IDX_W-1:0];
  assign inv_tag  = snp_addr[ADDR_W-1:IDX_W];
  assign inv_word = snp_addr;
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [DATA_W-1:0] lk_data,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [DATA_W-1:0] upd_data,
  output logic              fill_en,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [TAG_W-1:0]  fill_tag,
  output logic [DATA_W-1:0] fill_data,
  output logic              fill_ok,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx,
  input  logic [TAG_W-1:0]  inv_tag,
  input  logic [ADDR_W-1:0] inv_word
);
  wtc_state_e        state_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_wdata_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              poison_q;

  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              same_cycle_kill;
  logic              hit;
  logic              accept;
  logic              fetching;

  assign req_idx = cpu_req_addr[IDX_W-1:0];
  assign req_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign lk_idx  = req_idx;

  // invalidation in the acceptance cycle wins over the lookup
  assign same_cycle_kill = inv_en && (inv_idx == req_idx) && (inv_tag == req_tag);
  assign hit      = lk_valid && (lk_tag == req_tag) && !same_cycle_kill;
  assign accept   = cpu_req_valid && cpu_req_ready;
  assign fetching = (state_q == ST_RD_REQ) || (state_q == ST_RD_WAIT);

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_rsp_valid = (state_q == ST_RESP);
  assign cpu_rsp_rdata = rsp_data_q;

  assign bus_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign bus_req_write = (state_q == ST_WR_REQ);
  assign bus_req_addr  = pend_addr_q;
  assign bus_req_wdata = pend_wdata_q;

  assign upd_en   = accept && cpu_req_write && hit;
  assign upd_idx  = req_idx;
  assign upd_data = cpu_req_wdata;

  assign fill_en   = (state_q == ST_RD_WAIT) && bus_rsp_valid;
  assign fill_idx  = pend_addr_q[IDX_W-1:0];
  assign fill_tag  = pend_addr_q[ADDR_W-1:IDX_W];
  assign fill_data = bus_rsp_rdata;
  assign fill_ok   = !poison_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
      rsp_data_q   <= '0;
      poison_q     <= 1'b0;
    end else begin
      if (fetching && inv_en && (inv_word == pend_addr_q)) begin
        poison_q <= 1'b1;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            pend_addr_q  <= cpu_req_addr;
            pend_wdata_q <= cpu_req_wdata;
            poison_q     <= 1'b0;
            if (cpu_req_write) begin
              state_q <= ST_WR_REQ;
            end else if (hit) begin
              rsp_data_q <= lk_data;
              state_q    <= ST_RESP;
            end else begin
              state_q <= ST_RD_REQ;
            end
          end
        end
        ST_RD_REQ: begin
          if (bus_req_ready) state_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (bus_rsp_valid) begin
            rsp_data_q <= bus_rsp_rdata;
            state_q    <= ST_RESP;
          end
        end
        ST_WR_REQ: begin
          if (bus_req_ready) state_q <= ST_RESP;
        end
        ST_RESP: begin
          if (cpu_rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_wt_cache.sv
module snoop_wt_cache #(
  parameter int ADDR_W  = 30,
  parameter int DATA_W  = 32,
  parameter int LINES   = 16,
  parameter int SRC_W   = 3,
  parameter int SELF_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_rdata,
  input  logic              snp_valid,
  input  logic [SRC_W-1:0]  snp_src,
  input  logic [ADDR_W-1:0] snp_addr
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx;
  logic              lk_valid;
  logic [TAG_W-1:0]  lk_tag;
  logic [DATA_W-1:0] lk_data;
  logic              upd_en;
  logic [IDX_W-1:0]  upd_idx;
  logic [DATA_W-1:0] upd_data;
  logic              fill_en;
  logic [IDX_W-1:0]  fill_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic [DATA_W-1:0] fill_data;
  logic              fill_ok;
  logic              inv_en;
  logic [IDX_W-1:0]  inv_idx;
  logic [TAG_W-1:0]  inv_tag;
  logic [ADDR_W-1:0] inv_word;

  wtc_snoop_port #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SRC_W(SRC_W), .SELF_ID(SELF_ID)
  ) u_snoop (
    .snp_valid(snp_valid), .snp_src(snp_src), .snp_addr(snp_addr),
    .inv_en(inv_en), .inv_idx(inv_idx), .inv_tag(inv_tag), .inv_word(inv_word)
  );

  wtc_line_store #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_data(fill_data), .fill_ok(fill_ok),
    .inv_en(inv_en), .inv_idx(inv_idx), .inv_tag(inv_tag)
  );

  wtc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_data(fill_data), .fill_ok(fill_ok),
    .inv_en(inv_en), .inv_idx(inv_idx), .inv_tag(inv_tag), .inv_word(inv_word)
  );
endmodule

// File: rtl/snoop_wt_cache_chk.sv
module snoop_wt_cache_chk #(
  parameter int ADDR_W  = 30,
  parameter int DATA_W  = 32,
  parameter int SRC_W   = 3,
  parameter int SELF_ID = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_req_write,
  input logic [ADDR_W-1:0] cpu_req_addr,
  input logic [DATA_W-1:0] cpu_req_wdata,
  input logic              cpu_rsp_valid,
  input logic              cpu_rsp_ready,
  input logic [DATA_W-1:0] cpu_rsp_rdata,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic              bus_req_write,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic [DATA_W-1:0] bus_req_wdata,
  input logic              snp_valid,
  input logic [SRC_W-1:0]  snp_src,
  input logic [ADDR_W-1:0] snp_addr
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cpu_req_ready && !cpu_rsp_valid && !bus_req_valid));

  a_r3_single_bus_read: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && bus_req_ready && !bus_req_write) |=> !bus_req_valid);

  a_r4_write_through: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready && cpu_req_write) |=>
      (bus_req_valid && bus_req_write && bus_req_addr == $past(cpu_req_addr)
       && bus_req_wdata == $past(cpu_req_wdata)));

  a_r7_snoop_first: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready && !cpu_req_write && snp_valid
     && snp_src != SRC_W'(SELF_ID) && snp_addr == cpu_req_addr) |=>
      (bus_req_valid && !bus_req_write && bus_req_addr == $past(cpu_req_addr)));

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata)));

  a_r10_bus_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && !bus_req_ready) |=>
      (bus_req_valid && $stable(bus_req_write) && $stable(bus_req_addr)
       && $stable(bus_req_wdata)));

  a_r10_one_in_flight: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid |-> !cpu_req_ready);
endmodule

bind snoop_wt_cache snoop_wt_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .SELF_ID(SELF_ID)
) u_chk (.*);

// File: tb/snoop_wt_cache_test.sv
module snoop_wt_cache_test;
  localparam int AW = 30;
  localparam int DW = 32;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req_valid = 1'b0;
  logic          cpu_req_ready;
  logic          cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_rsp_valid;
  logic          cpu_rsp_ready = 1'b1;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          bus_req_valid;
  logic          bus_req_ready = 1'b0;
  logic          bus_req_write;
  logic [AW-1:0] bus_req_addr;
  logic [DW-1:0] bus_req_wdata;
  logic          bus_rsp_valid = 1'b0;
  logic [DW-1:0] bus_rsp_rdata = '0;
  logic          snp_valid = 1'b0;
  logic [SW-1:0] snp_src = '0;
  logic [AW-1:0] snp_addr = '0;

  always #2 clk = ~clk;

  snoop_wt_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(16), .SRC_W(SW), .SELF_ID(0)) uut (.*);

  int vectors = 0;
  int fails = 0;
  int nrd = 0;
  int nwr = 0;
  int force_lat = 0;
  bit force_rdy = 1'b0;
  bit backpressure = 1'b0;
  logic [DW-1:0] mem [64];
  bit  mv [16];
  int  mt [16];
  bit  inflight = 1'b0;
  logic [AW-1:0] inflight_a = '0;
  bit  poisoned = 1'b0;

  function automatic int widx(logic [AW-1:0] a);
    return int'(a[5:0]);
  endfunction
  function automatic logic [AW-1:0] mk(int tag, int idx);
    return AW'(tag * 16 + idx);
  endfunction
  function automatic bit exp_hit(logic [AW-1:0] a);
    return mv[int'(a[3:0])] && (mt[int'(a[3:0])] == int'(a[5:4]));
  endfunction

  task automatic chk(bit ok, string rq, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory and bus side
  initial begin
    int cnt = 0;
    logic [DW-1:0] rdq = '0;
    for (int i = 0; i < 64; i++) mem[i] = DW'(32'h1000 + i);
    forever begin
      @(posedge clk);
      if (rst) begin
        bus_req_ready <= 1'b0;
        bus_rsp_valid <= 1'b0;
        cnt = 0;
      end else begin
        bus_rsp_valid <= 1'b0;
        if (cnt > 0) begin
          cnt--;
          if (cnt == 0) begin
            bus_rsp_valid <= 1'b1;
            bus_rsp_rdata <= rdq;
          end
        end
        if (bus_req_valid && bus_req_ready) begin
          if (bus_req_write) begin
            mem[widx(bus_req_addr)] = bus_req_wdata;
            nwr++;
          end else begin
            rdq = mem[widx(bus_req_addr)];
            cnt = (force_lat > 0) ? force_lat : 1 + int'($urandom % 3);
            nrd++;
          end
        end
        bus_req_ready <= force_rdy ? 1'b1 : (($urandom % 3) != 0);
      end
    end
  end

  task automatic apply_snoop_model(logic [AW-1:0] a, logic [DW-1:0] d, int src);
    if (src != 0) begin
      mem[widx(a)] = d;
      if (exp_hit(a)) mv[int'(a[3:0])] = 1'b0;
      if (inflight && a == inflight_a) poisoned = 1'b1;
    end
  endtask

  task automatic snoop(logic [AW-1:0] a, logic [DW-1:0] d, int src);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = a; snp_src = SW'(src);
    apply_snoop_model(a, d, src);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic cpu_op(bit wr, logic [AW-1:0] a, logic [DW-1:0] wd,
                        bit co_snp, logic [DW-1:0] sd, string rq,
                        output logic [DW-1:0] rdata);
    int rd0, wr0, cyc, first;
    bit hit, held_seen;
    logic [DW-1:0] expd, held;
    @(negedge clk);
    rd0 = nrd; wr0 = nwr;
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
    if (co_snp) begin
      snp_valid = 1'b1; snp_addr = a; snp_src = 3'd5;
      apply_snoop_model(a, sd, 5);
    end
    hit = exp_hit(a);
    do @(posedge clk); while (!cpu_req_ready);
    expd = mem[widx(a)];
    inflight = !wr; inflight_a = a; poisoned = 1'b0;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (co_snp) snp_valid = 1'b0;
    cyc = 0; first = 0; held_seen = 1'b0; held = '0;
    forever begin
      cpu_rsp_ready = backpressure ? (($urandom % 2) != 0) : 1'b1;
      @(posedge clk);
      cyc++;
      if (cpu_rsp_valid && first == 0) first = cyc;
      if (cpu_rsp_valid && !cpu_rsp_ready) begin
        if (held_seen) chk(cpu_rsp_rdata == held, "R10 rsp hold", cpu_rsp_rdata, held);
        held = cpu_rsp_rdata; held_seen = 1'b1;
      end
      if (cpu_rsp_valid && cpu_rsp_ready) break;
      @(negedge clk);
    end
    rdata = cpu_rsp_rdata;
    if (held_seen) chk(rdata == held, "R10 rsp final", rdata, held);
    inflight = 1'b0;
    if (wr) begin
      chk(nwr - wr0 == 1, "R4 one bus write", DW'(nwr - wr0), 1);
      chk(mem[widx(a)] == wd, "R4 memory updated", mem[widx(a)], wd);
    end else begin
      chk(rdata == expd, {rq, " read data"}, rdata, expd);
      chk(nrd - rd0 == (hit ? 0 : 1), {rq, " bus reads"}, DW'(nrd - rd0), hit ? 0 : 1);
      if (hit && !backpressure) chk(first == 1, "R2 hit latency", DW'(first), 1);
      if (!hit && !poisoned) begin
        mv[int'(a[3:0])] = 1'b1;
        mt[int'(a[3:0])] = int'(a[5:4]);
      end
    end
    @(negedge clk);
    cpu_rsp_ready = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    logic [AW-1:0] a, b;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin mv[i] = 1'b0; mt[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state right after reset
    chk(cpu_req_ready == 1'b1, "R1 req ready", DW'(cpu_req_ready), 1);
    chk(cpu_rsp_valid == 1'b0, "R1 rsp idle", DW'(cpu_rsp_valid), 0);
    chk(bus_req_valid == 1'b0, "R1 bus idle", DW'(bus_req_valid), 0);

    a = mk(1, 3);
    cpu_op(0, a, '0, 0, '0, "R1 R3 first read misses", r);
    cpu_op(0, a, '0, 0, '0, "R2 read hit", r);
    cpu_op(1, a, 32'hAAAA0001, 0, '0, "R4", r);
    cpu_op(0, a, '0, 0, '0, "R4 write hit then read hit", r);
    b = mk(2, 9);
    cpu_op(1, b, 32'hBBBB0002, 0, '0, "R4", r);
    cpu_op(0, b, '0, 0, '0, "R4 write miss no allocate", r);
    // R9: same index, other tag
    snoop(mk(3, 3), 32'hC0C0C0C0, 4);
    cpu_op(0, a, '0, 0, '0, "R9 other tag keeps line", r);
    // R6: own source ignored
    snoop(a, 32'hDEAD0000, 0);
    cpu_op(0, a, '0, 0, '0, "R6 own snoop ignored", r);
    // R5: invalidation from another master
    snoop(a, 32'h55550005, 2);
    cpu_op(0, a, '0, 0, '0, "R5 snoop invalidates", r);
    // R7: same-cycle snoop on a read, then on a write
    cpu_op(0, a, '0, 1, 32'h77770007, "R7 snoop before read", r);
    cpu_op(0, a, '0, 0, '0, "R2 refilled", r);
    cpu_op(1, a, 32'h77770008, 1, 32'h77770009, "R7", r);
    cpu_op(0, a, '0, 0, '0, "R7 write leaves line invalid", r);
    // R8: snoop during an outstanding fill
    force_rdy = 1'b1; force_lat = 8;
    b = mk(0, 12);
    fork
      cpu_op(0, b, '0, 0, '0, "R8 stale word returned", r);
      begin repeat (3) @(posedge clk); snoop(b, 32'h88880008, 6); end
    join
    force_rdy = 1'b0; force_lat = 0;
    cpu_op(0, b, '0, 0, '0, "R8 next read misses", r);

    // random traffic over a few tags on four indices
    backpressure = 1'b1;
    for (int n = 0; n < 400; n++) begin
      int k;
      logic [AW-1:0] ra;
      k  = int'($urandom % 10);
      ra = mk(int'($urandom % 3), int'($urandom % 4));
      if (k < 4)       cpu_op(0, ra, '0, 0, '0, "R3 R5 random read", r);
      else if (k < 6)  cpu_op(1, ra, $urandom, 0, '0, "R4", r);
      else if (k < 8)  snoop(ra, $urandom, 1 + int'($urandom % 7));
      else if (k == 8) snoop(ra, $urandom, 0);
      else             cpu_op(0, ra, '0, 1, $urandom, "R7 random race", r);
    end
    backpressure = 1'b0;
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule